// File: doc/BRIEF.md
# System Status and Reset-Cause Register

This block gathers the slow-changing state of a low-power controller into one read-only status word. It keeps four sticky flags that record why the system last restarted or what last happened to its supply: a cold start after power-on reset, a restart through the power-fail input, a restart through the user reset button, and a rising edge on the battery-change input. Software reads the word to learn the cause, then writes once to a dedicated clear address. That single write clears all four flags. The write data is not used, so the bus carries no data lines into the block.

During power-on reset the block samples a two-bit boot bus-width strap. It keeps that value through every later reset that is not a power-on reset. The block also holds the prescaler that divides a 64 Hz tick down to the 1 Hz increment of the real-time clock. It sends the RTC a one-cycle pulse each time the prescaler wraps. The prescaler state appears in the status word with its bit order reversed. A group of status bits owned by other blocks, such as transmit-busy and FIFO levels, passes straight through into the word.

The clock keeps running during every kind of reset. All reset inputs are sampled on the clock. The tick input is a single-cycle enable that is synchronous to the clock.

Top module: `sys_status_reg`

## Requirements
- R1: While the power-on input `porN` is low, each clock edge sets the cold-start flag (word bit 6) and clears the power-fail (bit 7), button (bit 8) and battery (bit 9) flags.
- R2: While `porN` is low, the boot field (word bits 11:10) copies `bootStrap`. The encoding is 00 = 32-bit ROM bus, 01 = 8-bit, 10 = 16-bit and 11 = reserved. A power-fail or button reset leaves the field unchanged, and the field ignores later strap changes.
- R3: Any clock edge at which `pwrFailN` is low (and `porN` is high) sets the power-fail flag. The flag stays set after `pwrFailN` returns high.
- R4: Any clock edge at which `userRstN` is low (and `porN` is high) sets the button flag. The flag stays set after the input is released.
- R5: `battChg` passes through a two-flop synchronizer. A low-to-high change sets the battery flag at the third clock edge after the change. A level that stays high sets nothing further.
- R6: A `regWr` to `CLR_ADDR` clears all four flags at the next edge. A write to any other address changes no flag.
- R7: A set condition in the same cycle as a clear write wins, and the flag remains set.
- R8: Each clock edge with `tick64` high and no reset active advances a 6-bit prescaler by one. The word's bits 5:0 show the prescaler reversed, so bit 5 is the fastest (32 Hz) stage and bit 0 is the slowest (1 Hz) stage.
- R9: `rtcInc` is high for exactly one cycle after the tick that takes the prescaler from 63 to 0. That gives one pulse per 64 ticks.
- R10: Any reset (power-on, power-fail or button) clears the prescaler and `rtcInc`.
- R11: `rdData` shows the status word in the same cycle that `regRd` is high with `regAddr` equal to `STAT_ADDR`. Otherwise it is zero. `extStat` appears unchanged in word bits 19:12, and bits 31:20 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, running during all resets |
| porN | input | 1 | Power-on reset, active low |
| pwrFailN | input | 1 | Power-fail reset, active low |
| userRstN | input | 1 | Button reset, active low |
| battChg | input | 1 | Battery-change input, asynchronous |
| bootStrap | input | 2 | Boot bus-width strap pins |
| tick64 | input | 1 | 64 Hz tick, one-cycle enable |
| extStat | input | EXT_W | Status bits from other blocks, passed through |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe |
| regAddr | input | ADDR_W | Register address |
| rdData | output | DATA_W | Read data |
| rtcInc | output | 1 | One-cycle 1 Hz increment pulse to the RTC |

## Verification
The bench uses the default parameters: a 6-bit prescaler, 8 pass-through bits, a 4-bit address with the status word at 0 and the clear address at 8, and a 32-bit word. Because the prescaler is only 64 steps long, the bench can run several complete wraps and a run of partial counts. That lets it check the reversed bit order at asymmetric counts such as 10 and 43. The 8-bit pass-through is wide enough to carry an alternating pattern, which shows that the field sits at the right place.

// File: rtl/sys_status_pkg.sv
package sys_status_pkg;

  localparam int FLAG_N    = 4;
  localparam int FLAG_COLD = 0;
  localparam int FLAG_PF   = 1;
  localparam int FLAG_BTN  = 2;
  localparam int FLAG_BATT = 3;

  typedef enum logic [1:0] {
    BOOT_W32  = 2'b00,
    BOOT_W8   = 2'b01,
    BOOT_W16  = 2'b10,
    BOOT_RSVD = 2'b11
  } bootWidth_t;

  typedef struct packed {
    logic porHold;
    logic anyRst;
    logic clrFlags;
    logic pfSet;
    logic btnSet;
    logic battSet;
    logic tickAdv;
    logic wrapHit;
    logic rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/sys_status_ctrl.sv
module sys_status_ctrl
  import sys_status_pkg::*;
#(
  parameter int              PRESC_W   = 6,
  parameter int              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 'h8
) (
  input  logic               clk,
  input  logic               porN,
  input  logic               pwrFailN,
  input  logic               userRstN,
  input  logic               battChg,
  input  logic               tick64,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [PRESC_W-1:0] preCnt,
  output ctrlStrobe_t        strobe
);

  localparam int SYNC_N = 3;

  // Two flops for synchronization and a third that holds the previous level for edge detection.
  logic [SYNC_N-1:0] battPipe;
  logic              battRise;
  logic              anyRst;

  always_ff @(posedge clk) begin
    battPipe <= {battPipe[SYNC_N-2:0], battChg};
  end

  assign battRise = battPipe[SYNC_N-2] & ~battPipe[SYNC_N-1];
  assign anyRst   = ~(porN & pwrFailN & userRstN);

  always_comb begin
    strobe          = '0;
    strobe.porHold  = ~porN;
    strobe.anyRst   = anyRst;
    strobe.clrFlags = regWr && (regAddr == CLR_ADDR);
    strobe.pfSet    = ~pwrFailN;
    strobe.btnSet   = ~userRstN;
    strobe.battSet  = battRise;
    strobe.tickAdv  = tick64 & ~anyRst;
    strobe.wrapHit  = tick64 & ~anyRst & (&preCnt);
    strobe.rdSel    = regRd && (regAddr == STAT_ADDR);
  end

endmodule

// File: rtl/sys_status_dp.sv
module sys_status_dp
  import sys_status_pkg::*;
#(
  parameter int PRESC_W = 6,
  parameter int EXT_W   = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  ctrlStrobe_t        strobe,
  input  logic [1:0]         bootStrap,
  input  logic [EXT_W-1:0]   extStat,
  output logic [PRESC_W-1:0] preCnt,
  output logic [FLAG_N-1:0]  flagVec,
  output logic [1:0]         bootVal,
  output logic               rtcInc,
  output logic [DATA_W-1:0]  rdData
);

  localparam int FLAG_LO = PRESC_W;
  localparam int BOOT_LO = FLAG_LO + FLAG_N;
  localparam int EXT_LO  = BOOT_LO + 2;
  localparam int USED_W  = EXT_LO + EXT_W;

  logic [FLAG_N-1:0]  flagQ;
  logic [FLAG_N-1:0]  setVec;
  bootWidth_t         bootQ;
  logic [PRESC_W-1:0] cntQ;
  logic [PRESC_W-1:0] cntRev;
  logic               incQ;
  logic [DATA_W-1:0]  word;

  // Sticky flags: a set in the same cycle as a clear wins.
  always_comb begin
    setVec            = '0;
    setVec[FLAG_PF]   = strobe.pfSet;
    setVec[FLAG_BTN]  = strobe.btnSet;
    setVec[FLAG_BATT] = strobe.battSet;
  end

  always_ff @(posedge clk) begin
    if (strobe.porHold) begin
      flagQ            <= '0;
      flagQ[FLAG_COLD] <= 1'b1;
    end else begin
      flagQ <= setVec | (flagQ & ~{FLAG_N{strobe.clrFlags}});
    end
  end

  // The boot strap is captured only while power-on reset is held.
  always_ff @(posedge clk) begin
    if (strobe.porHold) bootQ <= bootWidth_t'(bootStrap);
  end

  // Divide-by-2^PRESC_W prescaler with its wrap pulse.
  always_ff @(posedge clk) begin
    if (strobe.anyRst) begin
      cntQ <= '0;
      incQ <= 1'b0;
    end else begin
      if (strobe.tickAdv) cntQ <= cntQ + 1'b1;
      incQ <= strobe.wrapHit;
    end
  end

  // Reverse the stage order so the fastest stage lands on the top bit.
  for (genvar gi = 0; gi < PRESC_W; gi++) begin : g_rev
    assign cntRev[PRESC_W-1-gi] = cntQ[gi];
  end

  always_comb begin
    word                      = '0;
    word[PRESC_W-1:0]         = cntRev;
    word[FLAG_LO +: FLAG_N]   = flagQ;
    word[BOOT_LO +: 2]        = bootQ;
    word[EXT_LO +: EXT_W]     = extStat;
  end

  assign rdData  = strobe.rdSel ? word : '0;
  assign preCnt  = cntQ;
  assign flagVec = flagQ;
  assign bootVal = bootQ;
  assign rtcInc  = incQ;

  if (USED_W > DATA_W) begin : g_width_err
    initial $error("status word too narrow for its fields");
  end

endmodule

// File: rtl/sys_status_reg.sv
module sys_status_reg
  import sys_status_pkg::*;
#(
  parameter int                PRESC_W   = 6,
  parameter int                EXT_W     = 8,
  parameter int                ADDR_W    = 4,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h0,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 'h8
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              pwrFailN,
  input  logic              userRstN,
  input  logic              battChg,
  input  logic [1:0]        bootStrap,
  input  logic              tick64,
  input  logic [EXT_W-1:0]  extStat,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              rtcInc
);

  ctrlStrobe_t        ctrlS;
  logic [PRESC_W-1:0] preCnt;
  logic [FLAG_N-1:0]  flagVec;
  logic [1:0]         bootVal;

  sys_status_ctrl #(
    .PRESC_W(PRESC_W), .ADDR_W(ADDR_W),
    .STAT_ADDR(STAT_ADDR), .CLR_ADDR(CLR_ADDR)
  ) u_ctrl (
    .clk(clk), .porN(porN), .pwrFailN(pwrFailN), .userRstN(userRstN),
    .battChg(battChg), .tick64(tick64), .regWr(regWr), .regRd(regRd),
    .regAddr(regAddr), .preCnt(preCnt), .strobe(ctrlS)
  );

  sys_status_dp #(
    .PRESC_W(PRESC_W), .EXT_W(EXT_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .strobe(ctrlS), .bootStrap(bootStrap), .extStat(extStat),
    .preCnt(preCnt), .flagVec(flagVec), .bootVal(bootVal),
    .rtcInc(rtcInc), .rdData(rdData)
  );

endmodule

// File: rtl/sys_status_chk.sv
module sys_status_chk
  import sys_status_pkg::*;
#(
  parameter int                PRESC_W  = 6,
  parameter int                ADDR_W   = 4,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CLR_ADDR = 'h8
) (
  input logic               clk,
  input logic               porN,
  input logic               pwrFailN,
  input logic               userRstN,
  input logic               tick64,
  input logic               regWr,
  input logic               regRd,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [PRESC_W-1:0] preCnt,
  input logic [FLAG_N-1:0]  flagVec,
  input logic [1:0]         bootVal,
  input logic               rtcInc,
  input logic [DATA_W-1:0]  rdData,
  input ctrlStrobe_t        ctrlS
);

  logic anyRst;
  logic clrWr;
  assign anyRst = ~(porN & pwrFailN & userRstN);
  assign clrWr  = regWr && (regAddr == CLR_ADDR);

  p_por_cold_r1: assert property (@(posedge clk)
    !porN |=> flagVec == 4'b0001);

  p_boot_hold_r2: assert property (@(posedge clk) disable iff (!porN)
    $past(porN) |-> bootVal == $past(bootVal));

  p_pf_set_r3: assert property (@(posedge clk) disable iff (!porN)
    !pwrFailN |=> flagVec[FLAG_PF]);

  p_btn_set_r4: assert property (@(posedge clk) disable iff (!porN)
    !userRstN |=> flagVec[FLAG_BTN]);

  p_clear_all_r6: assert property (@(posedge clk) disable iff (!porN)
    (clrWr && pwrFailN && userRstN && !ctrlS.battSet) |=> flagVec == '0);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!porN)
    !clrWr |=> (flagVec & $past(flagVec)) == $past(flagVec));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!porN)
    (clrWr && ctrlS.battSet) |=> flagVec[FLAG_BATT]);

  p_step_r8: assert property (@(posedge clk) disable iff (anyRst)
    tick64 |=> preCnt == PRESC_W'($past(preCnt) + 1'b1));

  p_hold_r8: assert property (@(posedge clk) disable iff (anyRst)
    !tick64 |=> $stable(preCnt));

  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (anyRst)
    rtcInc |-> preCnt == '0);

  p_one_pulse_r9: assert property (@(posedge clk) disable iff (anyRst)
    rtcInc |=> !rtcInc);

  p_presc_rst_r10: assert property (@(posedge clk)
    anyRst |=> (preCnt == '0 && !rtcInc));

  p_rd_idle_r11: assert property (@(posedge clk) disable iff (!porN)
    !regRd |-> rdData == '0);

endmodule

bind sys_status_reg sys_status_chk #(
  .PRESC_W(PRESC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLR_ADDR(CLR_ADDR)
) u_chk (
  .clk(clk), .porN(porN), .pwrFailN(pwrFailN), .userRstN(userRstN),
  .tick64(tick64), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
  .preCnt(preCnt), .flagVec(flagVec), .bootVal(bootVal), .rtcInc(rtcInc),
  .rdData(rdData), .ctrlS(ctrlS)
);

// File: tb/sys_status_reg_tb.sv
module sys_status_reg_tb;

  localparam logic [3:0] STAT_A = 4'h0;
  localparam logic [3:0] CLR_A  = 4'h8;

  // Each entry: tick count [15:8], expected reversed field [7:2], expected new pulses [1:0].
  localparam logic [15:0] TICK_TAB [8] = '{
    {8'd1,  6'b100000, 2'd0},
    {8'd1,  6'b010000, 2'd0},
    {8'd5,  6'b111000, 2'd0},
    {8'd56, 6'b111111, 2'd0},
    {8'd1,  6'b000000, 2'd1},
    {8'd64, 6'b000000, 2'd1},
    {8'd10, 6'b010100, 2'd0},
    {8'd33, 6'b110101, 2'd0}
  };

  logic        clk = 1'b0;
  logic        porN = 1'b0, pwrFailN = 1'b1, userRstN = 1'b1, battChg = 1'b0;
  logic [1:0]  bootStrap = 2'b10;
  logic        tick64 = 1'b0;
  logic [7:0]  extStat = 8'h00;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic [31:0] rdData;
  logic        rtcInc;

  int checks = 0;
  int fails  = 0;
  int incCnt = 0;
  logic [31:0] w;

  always #4 clk = ~clk;

  sys_status_reg u_dut (
    .clk(clk), .porN(porN), .pwrFailN(pwrFailN), .userRstN(userRstN),
    .battChg(battChg), .bootStrap(bootStrap), .tick64(tick64),
    .extStat(extStat), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .rdData(rdData), .rtcInc(rtcInc)
  );

  always @(negedge clk) if (rtcInc === 1'b1) incCnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readWord(output logic [31:0] v);
    @(negedge clk);
    regRd = 1'b1; regAddr = STAT_A;
    #1 v = rdData;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic writeAt(input logic [3:0] a);
    @(negedge clk);
    regWr = 1'b1; regAddr = a;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick64 = 1'b1;
    repeat (n) @(negedge clk);
    tick64 = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int expInc;
    // Power-on reset with straps at 16-bit.
    idle(4);
    porN = 1'b1;
    idle(2);
    readWord(w);
    check("R1 cold flags", {28'd0, w[9:6]}, 32'h1);
    check("R2 boot 16-bit", {30'd0, w[11:10]}, 32'h2);
    check("R10 prescaler zero", {26'd0, w[5:0]}, 32'h0);
    check("R11 upper zero", {12'd0, w[31:20]}, 32'h0);

    // Prescaler walk.
    expInc = 0;
    for (int i = 0; i < 8; i++) begin
      ticks(int'(TICK_TAB[i][15:8]));
      idle(1);
      expInc += int'(TICK_TAB[i][1:0]);
      readWord(w);
      check("R8 reversed field", {26'd0, w[5:0]}, {26'd0, TICK_TAB[i][7:2]});
      check("R9 pulse count", incCnt, expInc);
    end

    // Strap change after power-on, then button reset.
    bootStrap = 2'b01;
    ticks(5);
    @(negedge clk); userRstN = 1'b0;
    idle(2); userRstN = 1'b1;
    idle(1);
    readWord(w);
    check("R4 button flag", {28'd0, w[9:6]}, 32'h5);
    check("R2 boot held", {30'd0, w[11:10]}, 32'h2);
    check("R10 prescaler cleared", {26'd0, w[5:0]}, 32'h0);

    // Clear, then power-fail, then a write elsewhere.
    writeAt(CLR_A);
    readWord(w);
    check("R6 clear all", {28'd0, w[9:6]}, 32'h0);
    @(negedge clk); pwrFailN = 1'b0;
    idle(2); pwrFailN = 1'b1;
    idle(1);
    writeAt(STAT_A);
    writeAt(4'h3);
    readWord(w);
    check("R3 power-fail flag", {28'd0, w[9:6]}, 32'h2);
    check("R6 other address ignored", {28'd0, w[9:6]}, 32'h2);

    // Set beats clear in the same cycle.
    writeAt(CLR_A);
    @(negedge clk); pwrFailN = 1'b0; regWr = 1'b1; regAddr = CLR_A;
    @(negedge clk); pwrFailN = 1'b1; regWr = 1'b0;
    idle(1);
    readWord(w);
    check("R7 set wins", {28'd0, w[9:6]}, 32'h2);
    writeAt(CLR_A);

    // Battery edge timing through the synchronizer.
    @(negedge clk); battChg = 1'b1;
    @(negedge clk); @(negedge clk);
    regRd = 1'b1; regAddr = STAT_A; #1 w = rdData;
    check("R5 not yet after two edges", {31'd0, w[9]}, 32'h0);
    @(negedge clk); #1 w = rdData;
    regRd = 1'b0;
    check("R5 set at third edge", {31'd0, w[9]}, 32'h1);
    writeAt(CLR_A);
    idle(10);
    readWord(w);
    check("R5 level ignored", {31'd0, w[9]}, 32'h0);

    // Read decode and pass-through.
    extStat = 8'hA5;
    @(negedge clk);
    regRd = 1'b0; regAddr = STAT_A; #1 w = rdData;
    check("R11 no read gives zero", w, 32'h0);
    regRd = 1'b1; regAddr = CLR_A; #1 w = rdData;
    check("R11 other address zero", w, 32'h0);
    regAddr = STAT_A; #1 w = rdData;
    check("R11 pass-through", {24'd0, w[19:12]}, 32'hA5);
    @(negedge clk); regRd = 1'b0;

    // New power-on reset reloads boot and flags.
    bootStrap = 2'b11;
    @(negedge clk); userRstN = 1'b0; pwrFailN = 1'b0; porN = 1'b0;
    idle(3);
    porN = 1'b1; userRstN = 1'b1; pwrFailN = 1'b1;
    idle(1);
    readWord(w);
    check("R2 boot reserved reload", {30'd0, w[11:10]}, 32'h3);
    check("R1 power-on overrides others", {28'd0, w[9:6]}, 32'h1);
    summary();
  end

endmodule